// File: doc/BRIEF.md
# Focus Acquisition and Loss Supervisor

This block sequences the capture of optical focus and watches the loop once it is closed. After a start command it drives a triangular search waveform onto the focus actuator, bounded by a programmable offset and height and advanced by a programmable step on every sample. For each sample it compares the central-aperture sum and the normalised focus error with programmable levels. Lock is taken only in order: the aperture sum clears its start level, the focus-error magnitude clears its level, and then the focus error changes sign between two consecutive samples. At that point the loop filter is enabled.

While locked, a sample whose aperture sum falls under the drop level clears the focus-OK flag and freezes the loop-filter integrator. A sample back above that level returns to lock. If the loss lasts longer than a programmable number of clock cycles, the block passes through a one-cycle restart state and resumes the search from the last ramp position and direction, not from the bottom of the ramp. The laser-enable output is active low and is asserted in every state except idle. The loop filter itself lies outside this block.

Top module: `focus_lock_supervisor`

## Requirements
- R1: After synchronous reset the state is idle, ramp_out is 0, pid_enable, integ_hold and focus_ok are 0, and laser_on_n is 1.
- R2: start_req in idle loads ramp_out with ramp_offset, sets the search direction upward and makes laser_on_n 0 from the next cycle on. start_req in any other state has no effect.
- R3: On each sample taken during search or armed, the ramp rises by ramp_step. When pos+step reaches or passes min(offset+height, 2^RW-1) it stops at that top and turns down. While falling, a position at or below offset+step goes to offset and turns up; otherwise it drops by the step.
- R4: In search, focus_ok follows the last sample's test ca_sum >= ca_start_lvl. focus_ok is 1 in armed and locked and 0 in idle, dropout and restart.
- R5: A search sample with ca_sum >= ca_start_lvl and |fe_norm| >= fe_start_lvl (two's complement) moves to armed. An armed sample with ca_sum < ca_start_lvl returns to search and clears focus_ok.
- R6: Lock (pid_enable = 1) happens on an armed sample whose sign bit (negative versus zero-or-positive) differs from that of the previous armed sample. The first sample after entering armed never locks.
- R7: A locked sample with ca_sum < ca_drop_lvl enters dropout: integ_hold = 1, focus_ok = 0, pid_enable stays 1.
- R8: A dropout sample with ca_sum >= ca_drop_lvl returns to lock (integ_hold 0, focus_ok 1), and the loss timer restarts from zero at the next dropout.
- R9: Without recovery, dropout ends on the (loss_limit+1)-th clock edge after entry. The block then spends one cycle in restart, with pid_enable, integ_hold and focus_ok at 0 and laser_on_n at 0, and enters search. A recovery sample on the expiry edge takes priority.
- R10: After restart the search continues from the ramp position and direction held at the moment of loss.
- R11: ramp_out changes only on samples in search or armed, or on the start load. It is held in idle, locked, dropout and restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | Strobe marking a new CA/FE sample pair |
| ca_sum | input | DW | Central-aperture sum sample, unsigned |
| fe_norm | input | DW | Normalised focus error sample, two's complement |
| start_req | input | 1 | Start command, acted on in idle only |
| ca_start_lvl | input | DW | CA level that raises focus_ok during search |
| ca_drop_lvl | input | DW | CA level below which a locked loop drops out |
| fe_start_lvl | input | DW | Focus-error magnitude level for arming |
| ramp_offset | input | RW | Bottom of the search triangle |
| ramp_height | input | RW | Peak-to-peak height of the triangle |
| ramp_step | input | RW | Ramp increment per sample |
| loss_limit | input | TW | Dropout length in clock cycles before restart |
| ramp_out | output | RW | Search ramp value for the focus actuator |
| pid_enable | output | 1 | Focus loop filter enabled |
| integ_hold | output | 1 | Freeze the loop-filter integrator |
| focus_ok | output | 1 | Focus-OK flag |
| laser_on_n | output | 1 | Laser enable, active low |

## Verification
Two functions can act on the same edge: the dropout timeout and the recovery test on a fresh sample. The bench enters dropout with one sample, leaves the strobe low for exactly loss_limit cycles, and then presents a good sample on the edge where the timer expires. The run passes only if the loop stays locked with the hold released. A second run without that sample must show the one-cycle restart. A start command issued while locked and while searching is also checked, and the ramp and loop outputs must stay untouched.

// File: rtl/fas_pkg.sv
package fas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEARCH  = 3'd1,
        ST_ARMED   = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_DROP    = 3'd4,
        ST_RESTART = 3'd5
    } fas_state_e;

    typedef struct packed {
        logic ca_gate;   // CA at or above the start level
        logic ca_low;    // CA below the drop level
        logic fe_gate;   // |FE| at or above the FE level
        logic fe_neg;    // FE sign bit
    } fas_flags_t;

    function automatic logic ramp_moves(input fas_state_e s);
        return (s == ST_SEARCH) || (s == ST_ARMED);
    endfunction

    function automatic logic loop_closed(input fas_state_e s);
        return (s == ST_LOCKED) || (s == ST_DROP);
    endfunction

endpackage

// File: rtl/fas_level_cmp.sv
module fas_level_cmp #(
    parameter int DW = 12
) (
    input  logic [DW-1:0]        ca,
    input  logic signed [DW-1:0] fe,
    input  logic [DW-1:0]        ca_start,
    input  logic [DW-1:0]        ca_drop,
    input  logic [DW-1:0]        fe_start,
    output fas_pkg::fas_flags_t  flags
);
    logic [DW-1:0] fe_mag;

    always_comb begin
        fe_mag        = fe[DW-1] ? $unsigned(-fe) : $unsigned(fe);
        flags.ca_gate = (ca >= ca_start);
        flags.ca_low  = (ca < ca_drop);
        flags.fe_gate = (fe_mag >= fe_start);
        flags.fe_neg  = fe[DW-1];
    end
endmodule

// File: rtl/fas_tri_ramp.sv
module fas_tri_ramp #(
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step_en,
    input  logic [RW-1:0] lo,
    input  logic [RW-1:0] height,
    input  logic [RW-1:0] step,
    output logic [RW-1:0] pos
);
    localparam logic [RW:0] TOP = {1'b0, {RW{1'b1}}};

    logic [RW-1:0] pos_q;
    logic          rising_q;
    logic [RW:0]   hi_sum, hi_lim, up_nxt, dn_floor;

    always_comb begin
        hi_sum   = {1'b0, lo} + {1'b0, height};
        hi_lim   = (hi_sum > TOP) ? TOP : hi_sum;
        up_nxt   = {1'b0, pos_q} + {1'b0, step};
        dn_floor = {1'b0, lo} + {1'b0, step};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            rising_q <= 1'b1;
        end else if (load) begin
            pos_q    <= lo;
            rising_q <= 1'b1;
        end else if (step_en) begin
            if (rising_q) begin
                if (up_nxt >= hi_lim) begin
                    pos_q    <= hi_lim[RW-1:0];
                    rising_q <= 1'b0;
                end else begin
                    pos_q <= up_nxt[RW-1:0];
                end
            end else begin
                if ({1'b0, pos_q} <= dn_floor) begin
                    pos_q    <= lo;
                    rising_q <= 1'b1;
                end else begin
                    pos_q <= pos_q - step;
                end
            end
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/fas_loss_timer.sv
module fas_loss_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/fas_seq.sv
module fas_seq (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_vld,
    input  logic                start_req,
    input  fas_pkg::fas_flags_t flags,
    input  logic                expired,
    output fas_pkg::fas_state_e state,
    output logic                fok
);
    import fas_pkg::*;

    fas_state_e st_q;
    logic       fok_q;
    logic       prev_v_q;
    logic       prev_neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            fok_q      <= 1'b0;
            prev_v_q   <= 1'b0;
            prev_neg_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    fok_q <= 1'b0;
                    if (start_req) st_q <= ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (sample_vld) begin
                        fok_q <= flags.ca_gate;
                        if (flags.ca_gate && flags.fe_gate) begin
                            st_q     <= ST_ARMED;
                            prev_v_q <= 1'b0;
                        end
                    end
                end
                ST_ARMED: begin
                    if (sample_vld) begin
                        prev_v_q   <= 1'b1;
                        prev_neg_q <= flags.fe_neg;
                        if (!flags.ca_gate) begin
                            st_q  <= ST_SEARCH;
                            fok_q <= 1'b0;
                        end else if (prev_v_q && (flags.fe_neg != prev_neg_q)) begin
                            st_q <= ST_LOCKED;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (sample_vld && flags.ca_low) begin
                        st_q  <= ST_DROP;
                        fok_q <= 1'b0;
                    end
                end
                ST_DROP: begin
                    if (sample_vld && !flags.ca_low) begin
                        st_q  <= ST_LOCKED;
                        fok_q <= 1'b1;
                    end else if (expired) begin
                        st_q <= ST_RESTART;
                    end
                end
                ST_RESTART: begin
                    fok_q <= 1'b0;
                    st_q  <= ST_SEARCH;
                end
                default: begin
                    st_q  <= ST_IDLE;
                    fok_q <= 1'b0;
                end
            endcase
        end
    end

    assign state = st_q;
    assign fok   = fok_q;
endmodule

// File: rtl/focus_lock_supervisor.sv
module focus_lock_supervisor #(
    parameter int DW = 12,
    parameter int RW = 12,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_vld,
    input  logic [DW-1:0]        ca_sum,
    input  logic signed [DW-1:0] fe_norm,
    input  logic                 start_req,
    input  logic [DW-1:0]        ca_start_lvl,
    input  logic [DW-1:0]        ca_drop_lvl,
    input  logic [DW-1:0]        fe_start_lvl,
    input  logic [RW-1:0]        ramp_offset,
    input  logic [RW-1:0]        ramp_height,
    input  logic [RW-1:0]        ramp_step,
    input  logic [TW-1:0]        loss_limit,
    output logic [RW-1:0]        ramp_out,
    output logic                 pid_enable,
    output logic                 integ_hold,
    output logic                 focus_ok,
    output logic                 laser_on_n
);
    import fas_pkg::*;

    fas_flags_t flags;
    fas_state_e state;
    logic       expired;
    logic       ramp_load;
    logic       ramp_step_en;

    fas_level_cmp #(.DW(DW)) u_cmp (
        .ca       (ca_sum),
        .fe       (fe_norm),
        .ca_start (ca_start_lvl),
        .ca_drop  (ca_drop_lvl),
        .fe_start (fe_start_lvl),
        .flags    (flags)
    );

    fas_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .sample_vld (sample_vld),
        .start_req  (start_req),
        .flags      (flags),
        .expired    (expired),
        .state      (state),
        .fok        (focus_ok)
    );

    fas_loss_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_DROP),
        .limit   (loss_limit),
        .expired (expired)
    );

    assign ramp_load    = (state == ST_IDLE) && start_req;
    assign ramp_step_en = sample_vld && ramp_moves(state);

    fas_tri_ramp #(.RW(RW)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .load    (ramp_load),
        .step_en (ramp_step_en),
        .lo      (ramp_offset),
        .height  (ramp_height),
        .step    (ramp_step),
        .pos     (ramp_out)
    );

    assign pid_enable = loop_closed(state);
    assign integ_hold = (state == ST_DROP);
    assign laser_on_n = (state == ST_IDLE);
endmodule

// File: rtl/focus_lock_supervisor_chk.sv
module focus_lock_supervisor_chk #(
    parameter int DW = 12,
    parameter int RW = 12,
    parameter int TW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sample_vld,
    input logic [DW-1:0]        ca_sum,
    input logic signed [DW-1:0] fe_norm,
    input logic                 start_req,
    input logic [DW-1:0]        ca_start_lvl,
    input logic [DW-1:0]        ca_drop_lvl,
    input logic [DW-1:0]        fe_start_lvl,
    input logic [RW-1:0]        ramp_offset,
    input logic [RW-1:0]        ramp_height,
    input logic [RW-1:0]        ramp_step,
    input logic [TW-1:0]        loss_limit,
    input logic [RW-1:0]        ramp_out,
    input logic                 pid_enable,
    input logic                 integ_hold,
    input logic                 focus_ok,
    input logic                 laser_on_n
);
    p_hold_inside_loop_r7: assert property (@(posedge clk) disable iff (rst)
        integ_hold |-> pid_enable);

    p_hold_clears_fok_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(integ_hold) |-> !focus_ok);

    p_lock_has_fok_r6: assert property (@(posedge clk) disable iff (rst)
        (pid_enable && !integ_hold) |-> focus_ok);

    p_lock_from_fok_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pid_enable) |-> $past(focus_ok));

    p_ramp_still_in_loop_r11: assert property (@(posedge clk) disable iff (rst)
        (pid_enable && $past(pid_enable)) |-> $stable(ramp_out));

    p_ramp_still_idle_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(laser_on_n) && $past(!start_req) && laser_on_n) |-> $stable(ramp_out));

    p_laser_with_loop_r2: assert property (@(posedge clk) disable iff (rst)
        pid_enable |-> !laser_on_n);

    p_fok_off_idle_r4: assert property (@(posedge clk) disable iff (rst)
        laser_on_n |-> !focus_ok);
endmodule

bind focus_lock_supervisor focus_lock_supervisor_chk #(.DW(DW), .RW(RW), .TW(TW)) u_chk (.*);

// File: tb/sim_focus_lock_supervisor.sv
module sim_focus_lock_supervisor;
    localparam int DW = 12;
    localparam int RW = 12;
    localparam int TW = 16;
    localparam int C_OFF   = 100;
    localparam int C_HGT   = 400;
    localparam int C_STEP  = 37;
    localparam int C_CAST  = 300;
    localparam int C_CADR  = 200;
    localparam int C_FEST  = 50;
    localparam int C_LIM   = 20;
    localparam int RMAX    = (1 << RW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_vld = 1'b0;
    logic [DW-1:0] ca_in = '0;
    logic signed [DW-1:0] fe_in = '0;
    logic start_req = 1'b0;
    logic [RW-1:0] ramp_out;
    logic pid_enable, integ_hold, focus_ok, laser_on_n;

    int total = 0;
    int bad = 0;
    int ncyc = 0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_st = 0;   // 0 idle 1 search 2 armed 3 locked 4 drop 5 restart
    int m_pos = 0;
    bit m_up = 1'b1;
    bit m_fok = 1'b0;
    bit m_pv = 1'b0;
    bit m_pn = 1'b0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    focus_lock_supervisor #(.DW(DW), .RW(RW), .TW(TW)) u0 (
        .clk (clk), .rst (rst), .sample_vld (sample_vld),
        .ca_sum (ca_in), .fe_norm (fe_in), .start_req (start_req),
        .ca_start_lvl (DW'(C_CAST)), .ca_drop_lvl (DW'(C_CADR)),
        .fe_start_lvl (DW'(C_FEST)),
        .ramp_offset (RW'(C_OFF)), .ramp_height (RW'(C_HGT)),
        .ramp_step (RW'(C_STEP)), .loss_limit (TW'(C_LIM)),
        .ramp_out (ramp_out), .pid_enable (pid_enable),
        .integ_hold (integ_hold), .focus_ok (focus_ok),
        .laser_on_n (laser_on_n)
    );

    task automatic model_ramp();
        int top;
        top = C_OFF + C_HGT;
        if (top > RMAX) top = RMAX;
        if (m_up) begin
            if (m_pos + C_STEP >= top) begin m_pos = top; m_up = 1'b0; end
            else m_pos = m_pos + C_STEP;
        end else begin
            if (m_pos <= C_OFF + C_STEP) begin m_pos = C_OFF; m_up = 1'b1; end
            else m_pos = m_pos - C_STEP;
        end
    endtask

    always @(posedge clk) begin
        int ca, fe, mag;
        bit neg;
        ncyc++;
        ca  = int'(ca_in);
        fe  = int'(fe_in);
        neg = (fe < 0);
        mag = neg ? -fe : fe;
        if (rst) begin
            m_st = 0; m_pos = 0; m_up = 1'b1; m_fok = 1'b0;
            m_pv = 1'b0; m_pn = 1'b0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (start_req) begin m_st = 1; m_pos = C_OFF; m_up = 1'b1; m_fok = 1'b0; end
                1: if (sample_vld) begin
                    model_ramp();
                    m_fok = (ca >= C_CAST);
                    if (ca >= C_CAST && mag >= C_FEST) begin m_st = 2; m_pv = 1'b0; end
                end
                2: if (sample_vld) begin
                    model_ramp();
                    if (ca < C_CAST) begin m_st = 1; m_fok = 1'b0; end
                    else if (m_pv && (neg != m_pn)) m_st = 3;
                    m_pn = neg;
                    m_pv = 1'b1;
                end
                3: begin
                    m_cnt = 0;
                    if (sample_vld && ca < C_CADR) begin m_st = 4; m_fok = 1'b0; end
                end
                4: begin
                    if (sample_vld && ca >= C_CADR) begin m_st = 3; m_fok = 1'b1; m_cnt = 0; end
                    else if (m_cnt >= C_LIM) begin m_st = 5; m_cnt = 0; end
                    else m_cnt++;
                end
                default: begin m_st = 1; m_fok = 1'b0; end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 ramp_out", int'(ramp_out), m_pos);
            chk("R6 pid_enable", int'(pid_enable), int'(m_st == 3 || m_st == 4));
            chk("R7 integ_hold", int'(integ_hold), int'(m_st == 4));
            chk("R4 focus_ok", int'(focus_ok), int'(m_fok));
            chk("R2 laser_on_n", int'(laser_on_n), int'(m_st == 0));
        end
    end

    always @(posedge clk) begin
        if (ncyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input bit v, input int ca, input int fe, input bit st);
        sample_vld = v;
        ca_in      = DW'(ca);
        fe_in      = DW'(fe);
        start_req  = st;
        @(posedge clk);
        @(negedge clk);
        sample_vld = 1'b0;
        start_req  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 0, 0, 1'b0);
    endtask

    task automatic smp(input int ca, input int fe);
        cyc(1'b1, ca, fe, 1'b0);
        idle(3);
    endtask

    initial begin
        int r_lock, r_hold;
        bit saw_top, saw_bot;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1 reset state
        chk("R1 ramp_out", int'(ramp_out), 0);
        chk("R1 pid_enable", int'(pid_enable), 0);
        chk("R1 integ_hold", int'(integ_hold), 0);
        chk("R1 focus_ok", int'(focus_ok), 0);
        chk("R1 laser_on_n", int'(laser_on_n), 1);

        // R11 samples in idle leave the ramp alone
        smp(400, 100);
        chk("R11 idle ramp", int'(ramp_out), 0);
        chk("R4 idle fok", int'(focus_ok), 0);

        // R2 start loads the offset
        cyc(1'b1, 50, 0, 1'b1);
        chk("R2 start load", int'(ramp_out), C_OFF);
        chk("R2 laser on", int'(laser_on_n), 0);

        // R3 sweep through both turnarounds
        saw_top = 1'b0;
        saw_bot = 1'b0;
        for (int i = 0; i < 30; i++) begin
            smp(50, 0);
            if (int'(ramp_out) == C_OFF + C_HGT) saw_top = 1'b1;
            if (saw_top && int'(ramp_out) == C_OFF) saw_bot = 1'b1;
        end
        chk("R3 reached top", int'(saw_top), 1);
        chk("R3 reached bottom", int'(saw_bot), 1);

        // R4 focus_ok tracks CA gate in search
        smp(350, 20);
        chk("R4 fok raised", int'(focus_ok), 1);
        chk("R5 small FE no lock", int'(pid_enable), 0);
        smp(250, 20);
        chk("R4 fok cleared", int'(focus_ok), 0);

        // R5 arming and fall-back to search
        smp(350, 90);
        chk("R5 armed fok", int'(focus_ok), 1);
        smp(250, -90);
        chk("R5 back to search", int'(focus_ok), 0);
        chk("R5 no lock", int'(pid_enable), 0);

        // R6 first armed sample never locks, sign change does
        smp(350, 90);
        smp(350, -90);
        chk("R6 first armed sample", int'(pid_enable), 0);
        smp(350, -60);
        chk("R6 same sign", int'(pid_enable), 0);
        smp(350, 0);
        chk("R6 lock on crossing", int'(pid_enable), 1);
        r_lock = int'(ramp_out);

        // R2 start ignored while locked
        cyc(1'b0, 0, 0, 1'b1);
        chk("R2 start ignored locked", int'(ramp_out), r_lock);
        chk("R2 still locked", int'(pid_enable), 1);

        // R7 short dropout, R8 recovery
        smp(150, 0);
        chk("R7 hold", int'(integ_hold), 1);
        chk("R7 fok low", int'(focus_ok), 0);
        chk("R7 pid kept", int'(pid_enable), 1);
        chk("R11 ramp held in dropout", int'(ramp_out), r_lock);
        smp(250, 0);
        chk("R8 recovered hold", int'(integ_hold), 0);
        chk("R8 recovered fok", int'(focus_ok), 1);

        // R9 recovery on the expiry edge wins
        cyc(1'b1, 150, 0, 1'b0);
        idle(C_LIM);
        chk("R9 still in dropout", int'(integ_hold), 1);
        cyc(1'b1, 250, 0, 1'b0);
        chk("R9 recovery priority pid", int'(pid_enable), 1);
        chk("R9 recovery priority hold", int'(integ_hold), 0);
        chk("R8 recovery fok", int'(focus_ok), 1);
        idle(3);

        // R9 timeout, R10 resume from held ramp
        r_hold = int'(ramp_out);
        cyc(1'b1, 150, 0, 1'b0);
        idle(C_LIM);
        chk("R9 hold before expiry", int'(integ_hold), 1);
        idle(1);
        chk("R9 restart pid", int'(pid_enable), 0);
        chk("R9 restart hold", int'(integ_hold), 0);
        chk("R9 restart fok", int'(focus_ok), 0);
        chk("R9 restart laser", int'(laser_on_n), 0);
        chk("R10 ramp kept", int'(ramp_out), r_hold);
        idle(1);
        chk("R9 back to search", int'(pid_enable), 0);
        smp(50, 0);
        chk("R10 resumed step", int'(ramp_out), m_pos);
        chk("R10 not from bottom", int'(ramp_out != C_OFF + C_STEP), 1);

        // R2 start ignored while searching
        r_hold = int'(ramp_out);
        cyc(1'b0, 0, 0, 1'b1);
        chk("R2 start ignored search", int'(ramp_out), r_hold);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule